// File: doc/BRIEF.md
# Selectable Table Waveform Sample Source

This block feeds an 8-bit digital-to-analog converter with one of three periodic shapes: square, triangle or sine. A 2-bit select input picks the shape. Each period has 16 samples held in fixed internal tables. A free-running counter on the system clock sets the sample rate. With the default divide of 5,000,000 on a 40 MHz clock, samples arrive at 8 Hz and one period lasts 2 seconds. All logic runs on the one clock and no clock is derived.

The current sample is presented as a level on `dac_sample`. The block also shows it in decimal on three active-low seven-segment digit outputs: hundreds, tens and units. The output stream has no ready input because a converter cannot stall. `sample_strobe` pulses for one cycle in the first cycle of each new phase, and the sample holds until the next pulse. A change of select takes effect at once in that sample, without moving the phase.

Top module: `wavegen_top`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted and in the cycle after it is released, the phase is 0 and `sample_strobe` is low, so `dac_sample` equals entry 0 of the selected table.
- R2: `sample_strobe` is high for exactly one cycle in every `TICK_DIV` clock cycles and is never high in two cycles in a row.
- R3: Each strobe marks a phase one greater than the previous one. The phase is 4 bits and wraps from 15 to 0, and it changes only at a strobe.
- R4: Select 2'b00 gives a square wave: 255 for phases 0 to 7 and 0 for phases 8 to 15.
- R5: Select 2'b01 gives a triangle wave: floor(255·m/8) with m = k for k ≤ 8 and m = 16−k otherwise. This is 0 at phase 0 and 255 at phase 8.
- R6: Select 2'b10 gives a sine wave: round(127.5 + 127.5·sin(2πk/16)), with halves rounded up.
- R7: Select 2'b11 gives a constant sample of 0.
- R8: A change on `wave_sel` changes `dac_sample` in the same cycle, combinationally, and leaves the phase and the strobe timing unchanged.
- R9: `seg_hund`, `seg_tens` and `seg_ones` show the decimal hundreds, tens and units digits of `dac_sample`. Leading zeros are shown.
- R10: Each digit output is active low. Bit 0 to bit 6 drive segments a to g. Bit 7 is the decimal point and is always 1 (off). Digits 0 to 9 use the usual patterns: active-high 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| wave_sel | input | 2 | Shape select: 00 square, 01 triangle, 10 sine, 11 zero |
| dac_sample | output | 8 | Current unsigned sample for the converter |
| sample_strobe | output | 1 | One-cycle pulse in the first cycle of each new phase |
| seg_hund | output | 8 | Hundreds digit, active-low segments, bit 7 decimal point |
| seg_tens | output | 8 | Tens digit, same coding |
| seg_ones | output | 8 | Units digit, same coding |

## Verification
Each shape is held across several full periods. This shows that every table entry is right at the phase where it belongs and that the wrap from 15 to 0 is clean. Random select changes between and inside phases test that the sample follows the select at once while the phase and the strobe spacing stay put. Steady runs alone cannot expose this. The zero code and the extremes 0 and 255 exercise the digit encoding at its ends, and the sine values exercise every digit position.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;
  localparam int SAMPLE_W = 8;
  localparam int PHASES   = 16;
  localparam int PHASE_W  = $clog2(PHASES);
  localparam int DIGITS   = 3;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [PHASE_W-1:0]  phase_t;

  typedef enum logic [1:0] {
    SHAPE_SQUARE = 2'b00,
    SHAPE_TRI    = 2'b01,
    SHAPE_SINE   = 2'b10,
    SHAPE_NONE   = 2'b11
  } shape_e;

  function automatic sample_t square_at(phase_t k);
    return k[PHASE_W-1] ? sample_t'(0) : sample_t'(255);
  endfunction

  function automatic sample_t tri_at(phase_t k);
    logic [PHASE_W:0] m;
    logic [11:0]      prod;
    m    = (k <= phase_t'(PHASES/2)) ? {1'b0, k} : (5'(PHASES) - {1'b0, k});
    prod = 12'(m) * 12'd255;
    return prod[10:3];
  endfunction

  function automatic sample_t sine_at(phase_t k);
    sample_t v;
    case (k)
      4'd0:  v = 8'd128;
      4'd1:  v = 8'd176;
      4'd2:  v = 8'd218;
      4'd3:  v = 8'd245;
      4'd4:  v = 8'd255;
      4'd5:  v = 8'd245;
      4'd6:  v = 8'd218;
      4'd7:  v = 8'd176;
      4'd8:  v = 8'd128;
      4'd9:  v = 8'd79;
      4'd10: v = 8'd37;
      4'd11: v = 8'd10;
      4'd12: v = 8'd0;
      4'd13: v = 8'd10;
      4'd14: v = 8'd37;
      default: v = 8'd79;
    endcase
    return v;
  endfunction

  function automatic logic [4*DIGITS-1:0] to_bcd(sample_t b);
    logic [4*DIGITS-1:0] acc;
    acc = '0;
    for (int i = SAMPLE_W-1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (acc[4*d +: 4] >= 4'd5) acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
      end
      acc = {acc[4*DIGITS-2:0], b[i]};
    end
    return acc;
  endfunction

  function automatic logic [6:0] seg_on(logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h40;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/wg_tick_div.sv
module wg_tick_div #(
  parameter int TICK_DIV = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/wg_phase.sv
module wg_phase
  import wavegen_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  output phase_t phase,
  output logic   strobe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= tick;
      if (tick) phase <= phase + 1'b1;
    end
  end

  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    strobe |-> phase == phase_t'($past(phase) + 1'b1));
  p_phase_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> (phase == $past(phase) || $past(rst)));
endmodule

// File: rtl/wg_sample_sel.sv
module wg_sample_sel
  import wavegen_pkg::*;
(
  input  phase_t     phase,
  input  logic [1:0] sel,
  output sample_t    sample
);
  sample_t lane [4];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    if (g == int'(SHAPE_SQUARE)) begin : g_sq
      assign lane[g] = square_at(phase);
    end else if (g == int'(SHAPE_TRI)) begin : g_tri
      assign lane[g] = tri_at(phase);
    end else if (g == int'(SHAPE_SINE)) begin : g_sin
      assign lane[g] = sine_at(phase);
    end else begin : g_zero
      assign lane[g] = '0;
    end
  end

  assign sample = lane[sel];

  always_comb begin
    if (!$isunknown({sel, sample}) && sel == 2'b11)
      p_idle_zero_r7: assert (sample == '0);
  end
endmodule

// File: rtl/wg_dec7.sv
module wg_dec7
  import wavegen_pkg::*;
(
  input  sample_t     value,
  output logic [7:0]  seg [DIGITS]
);
  logic [4*DIGITS-1:0] bcd;

  assign bcd = to_bcd(value);

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    assign seg[d] = {1'b1, ~seg_on(bcd[4*d +: 4])};
  end

  always_comb begin
    if (!$isunknown(value)) begin
      p_bcd_value_r9: assert (32'(bcd[11:8]) * 100 + 32'(bcd[7:4]) * 10
                              + 32'(bcd[3:0]) == 32'(value));
      p_dp_off_r10: assert (seg[0][7] && seg[1][7] && seg[2][7]);
    end
  end
endmodule

// File: rtl/wavegen_top.sv
module wavegen_top
  import wavegen_pkg::*;
#(
  parameter int TICK_DIV = 5_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] wave_sel,
  output logic [7:0] dac_sample,
  output logic       sample_strobe,
  output logic [7:0] seg_hund,
  output logic [7:0] seg_tens,
  output logic [7:0] seg_ones
);
  logic       tick;
  phase_t     phase;
  sample_t    sample;
  logic [7:0] seg [DIGITS];

  wg_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  wg_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .phase (phase),
    .strobe(sample_strobe)
  );

  wg_sample_sel u_sel (
    .phase (phase),
    .sel   (wave_sel),
    .sample(sample)
  );

  wg_dec7 u_dec (
    .value(sample),
    .seg  (seg)
  );

  assign dac_sample = sample;
  assign seg_ones   = seg[0];
  assign seg_tens   = seg[1];
  assign seg_hund   = seg[2];

  p_sel_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (wave_sel != $past(wave_sel) && !sample_strobe && !$past(rst))
      |-> $stable(phase));
endmodule

// File: tb/wavegen_top_tb.sv
module wavegen_top_tb;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] wave_sel = 2'b00;
  logic [7:0] dac_sample, seg_hund, seg_tens, seg_ones;
  logic       sample_strobe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ph_exp = 0;

  always #2.5 clk = ~clk;

  wavegen_top #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .wave_sel(wave_sel),
    .dac_sample(dac_sample), .sample_strobe(sample_strobe),
    .seg_hund(seg_hund), .seg_tens(seg_tens), .seg_ones(seg_ones)
  );

  function automatic int exp_sample(int sel, int k);
    real r;
    int m;
    case (sel)
      0: return (k < 8) ? 255 : 0;
      1: begin m = (k <= 8) ? k : 16 - k; return (255 * m) / 8; end
      2: begin
        r = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * k / 16.0);
        return $rtoi(r + 0.5);
      end
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_seg(int d);
    logic [6:0] p;
    case (d)
      0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F; 4: p = 7'h66;
      5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07; 8: p = 7'h7F; default: p = 7'h6F;
    endcase
    return {1'b1, ~p};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_out(string req);
    int v;
    v = exp_sample(int'(wave_sel), ph_exp);
    check(req, int'(dac_sample), v);
    check("R9/R10 hundreds", int'(seg_hund), int'(exp_seg(v / 100)));
    check("R9/R10 tens", int'(seg_tens), int'(exp_seg((v / 10) % 10)));
    check("R9/R10 units", int'(seg_ones), int'(exp_seg(v % 10)));
  endtask

  function automatic string req_of(logic [1:0] s);
    case (s)
      2'b00: return "R4 square";
      2'b01: return "R5 triangle";
      2'b10: return "R6 sine";
      default: return "R7 zero";
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic next_strobe(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      if (sample_strobe) begin
        @(negedge clk);
        gap++;
        check("R2 strobe one cycle", int'(sample_strobe), 0);
        break;
      end
    end while (1);
  endtask

  initial begin
    int gap;
    int seed;
    seed = $urandom(32'd1357);
    wave_sel = 2'b10;
    repeat (4) @(negedge clk);
    // R1: outputs while reset is held
    check("R1 strobe low in reset", int'(sample_strobe), 0);
    ph_exp = 0;
    check_out("R1 reset sample");
    rst = 1'b0;
    @(negedge clk);
    check("R1 strobe low after release", int'(sample_strobe), 0);
    check_out("R1 phase 0 after release");

    // directed: each shape over two full periods, phases 0..15 each
    for (int s = 0; s < 4; s++) begin
      wave_sel = 2'(s);
      #0.1;
      check_out({req_of(2'(s)), " R8 immediate"});
      for (int n = 0; n < 32; n++) begin
        next_strobe(gap);
        ph_exp = (ph_exp + 1) % 16;
        // sampled one cycle after the strobe; phase still held (R3)
        check_out(req_of(wave_sel));
        if (!(s == 0 && n == 0)) check("R2 strobe period", gap, DIV);
      end
    end

    // random select changes inside phases (R8, R3)
    for (int n = 0; n < 120; n++) begin
      int wait_c;
      wait_c = int'($urandom_range(0, DIV - 3));
      repeat (wait_c) @(negedge clk);
      if (!sample_strobe) begin
        wave_sel = 2'($urandom_range(0, 3));
        #0.1;
        check_out({req_of(wave_sel), " R8 switch keeps phase"});
      end
      next_strobe(gap);
      ph_exp = (ph_exp + 1) % 16;
      check_out({req_of(wave_sel), " R3 advance"});
    end

    // mid-run reset returns phase to 0 (R1)
    @(negedge clk);
    rst = 1'b1;
    wave_sel = 2'b01;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    ph_exp = 0;
    @(negedge clk);
    check_out("R1 phase 0 after mid-run reset");
    next_strobe(gap);
    check("R2 first period after reset", gap, DIV + 1);
    ph_exp = 1;
    check_out("R5 triangle after reset");

    finish_run();
  end
endmodule